// File: doc/BRIEF.md
# System-Management Memory Window Decoder

This block sits in a memory controller's address path and decides whether a host address falls inside one of three protected memory windows reserved for system-management code. The first is a compatible window in the legacy video range. The second is a high window just above 256 MiB that is redirected onto the same legacy DRAM. The third is a power-of-two segment carved from the very top of installed memory. A master enable bit in the global control register gates all three windows.

Three byte-wide configuration registers sit behind a simple write/read port: a global control register, an extended control register, and a row-top register that sets the amount of installed memory in 8 MiB steps. Each cycle the block also reports the remapped DRAM address and the highest address that remains usable by the operating system. All hit, remap and usable-top results are combinational from the current host address and the register contents.

Top module: `smm_window_decoder`

## Requirements
- R1: After reset the global control register reads 0x02 and the extended control and row-top registers read 0x00. No window hits, and the usable top is 0.
- R2: The global control register (select 0) reads bits [2:0] as 3'b010 whatever is written. Bits [7:3] read back as written, and bit 3 is the master enable.
- R3: Select 1 reads back the extended control register as written. In that register bit 7 enables the high window, bits [2:1] give the segment size code, and bit 0 enables the top segment. Select 2 reads back the row-top register, and select 3 reads 0x00.
- R4: Top of memory equals the row-top value times 0x0080_0000. While the top segment is inactive, usable_top equals top of memory.
- R5: The segment size is 0x0002_0000 shifted left by the size code (codes 0..3 give 128 KiB, 256 KiB, 512 KiB and 1 MiB). While the segment is active, usable_top equals top of memory minus that size, or 0 if the size exceeds top of memory.
- R6: The top segment is active only when the master enable and the segment enable are both 1. hit_tseg is then 1 exactly for addresses from usable_top up to top of memory minus one.
- R7: With the master enable and the high enable both 1, addresses 0x100A_0000..0x100F_FFFF raise hit_high, and dram_addr equals the host address minus 0x1000_0000.
- R8: With the master enable 1 and the high enable 0, addresses 0x000A_0000..0x000B_FFFF raise hit_compat. Outside a high hit, dram_addr equals the host address.
- R9: With the master enable 0, no hit output is raised and dram_addr equals the host address, whatever the extended register holds.
- R10: A register write appears at the outputs only after the clock edge that captures it. Before that edge, the outputs still reflect the old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 global, 1 extended, 2 row-top |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected register |
| host_addr | input | 32 | Host address to decode |
| hit_compat | output | 1 | Address in compatible window |
| hit_high | output | 1 | Address in high window |
| hit_tseg | output | 1 | Address in top segment |
| dram_addr | output | 32 | Remapped DRAM address |
| usable_top | output | 32 | First address above OS-usable DRAM |

## Verification
Hits, dram_addr, usable_top and read data depend on the address and select with no register in between, so they are due in the same cycle the address is applied. A register write is due one rising edge after the strobe. The bench drives every stimulus 1 ns after a rising edge and compares it at the following falling edge. For writes, it compares once before the capturing edge, expecting the old results, and once after it, expecting the new ones.

// File: rtl/smm_dec_pkg.sv
package smm_dec_pkg;
  localparam int AW         = 32;
  localparam int RW         = 8;
  localparam int ROW_SHIFT  = 23;
  localparam int SEG_SHIFT  = 17;
  localparam int G_EN_BIT   = 3;
  localparam int HI_EN_BIT  = 7;
  localparam int SEG_EN_BIT = 0;
  localparam int CODE_LSB   = 1;

  typedef enum logic [1:0] {
    SEL_GLOBAL = 2'd0,
    SEL_EXT    = 2'd1,
    SEL_ROWTOP = 2'd2,
    SEL_NONE   = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic          g_en;
    logic          high_en;
    logic          seg_en;
    logic [1:0]    seg_code;
    logic [RW-1:0] row_top;
  } smm_ctl_t;

  function automatic logic [AW-1:0] mem_top(input logic [RW-1:0] row);
    return {{(AW-RW){1'b0}}, row} << ROW_SHIFT;
  endfunction

  function automatic logic [AW-1:0] seg_size(input logic [1:0] code);
    return {{(AW-1){1'b0}}, 1'b1} << (SEG_SHIFT + int'(code));
  endfunction

  function automatic logic [AW-1:0] floor_sub(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (b > a) ? '0 : (a - b);
  endfunction

  function automatic logic in_win(input logic [AW-1:0] a, input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/smm_cfg_regs.sv
module smm_cfg_regs
  import smm_dec_pkg::*;
#(
  parameter logic [2:0] FIXED_LOW = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  cfg_sel_e      sel,
  input  logic [RW-1:0] wdata,
  output logic [RW-1:0] rdata,
  output smm_ctl_t      ctl
);
  logic [RW-1:3] glob_q;
  logic [RW-1:0] ext_q;
  logic [RW-1:0] row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glob_q <= '0;
      ext_q  <= '0;
      row_q  <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_GLOBAL: glob_q <= wdata[RW-1:3];
        SEL_EXT:    ext_q  <= wdata;
        SEL_ROWTOP: row_q  <= wdata;
        default:    ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_GLOBAL: rdata = {glob_q, FIXED_LOW};
      SEL_EXT:    rdata = ext_q;
      SEL_ROWTOP: rdata = row_q;
      default:    rdata = '0;
    endcase
  end

  assign ctl.g_en     = glob_q[G_EN_BIT];
  assign ctl.high_en  = ext_q[HI_EN_BIT];
  assign ctl.seg_en   = ext_q[SEG_EN_BIT];
  assign ctl.seg_code = ext_q[CODE_LSB+1:CODE_LSB];
  assign ctl.row_top  = row_q;
endmodule

// File: rtl/smm_top_calc.sv
module smm_top_calc
  import smm_dec_pkg::*;
(
  input  logic          g_en,
  input  logic          seg_en,
  input  logic [1:0]    seg_code,
  input  logic [RW-1:0] row_top,
  output logic [AW-1:0] tom,
  output logic          seg_active,
  output logic [AW-1:0] usable_top
);
  assign tom        = mem_top(row_top);
  assign seg_active = g_en && seg_en;
  assign usable_top = seg_active ? floor_sub(tom, seg_size(seg_code)) : tom;
endmodule

// File: rtl/smm_window_match.sv
module smm_window_match
  import smm_dec_pkg::*;
#(
  parameter logic [AW-1:0] COMPAT_LO = 32'h000A_0000,
  parameter logic [AW-1:0] COMPAT_HI = 32'h000B_FFFF,
  parameter logic [AW-1:0] HIGH_LO   = 32'h100A_0000,
  parameter logic [AW-1:0] HIGH_HI   = 32'h100F_FFFF,
  parameter logic [AW-1:0] HIGH_OFS  = 32'h1000_0000
) (
  input  logic [AW-1:0] host_addr,
  input  logic          g_en,
  input  logic          high_en,
  input  logic          seg_active,
  input  logic [AW-1:0] tom,
  input  logic [AW-1:0] usable_top,
  output logic          hit_compat,
  output logic          hit_high,
  output logic          hit_tseg,
  output logic [AW-1:0] dram_addr
);
  assign hit_compat = g_en && !high_en && in_win(host_addr, COMPAT_LO, COMPAT_HI);
  assign hit_high   = g_en &&  high_en && in_win(host_addr, HIGH_LO, HIGH_HI);
  assign hit_tseg   = seg_active && (host_addr >= usable_top) && (host_addr < tom);
  assign dram_addr  = hit_high ? (host_addr - HIGH_OFS) : host_addr;
endmodule

// File: rtl/smm_window_decoder.sv
module smm_window_decoder
  import smm_dec_pkg::*;
#(
  parameter logic [2:0] FIXED_LOW = 3'b010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr_en,
  input  logic [1:0]    cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic [31:0]   host_addr,
  output logic          hit_compat,
  output logic          hit_high,
  output logic          hit_tseg,
  output logic [31:0]   dram_addr,
  output logic [31:0]   usable_top
);
  smm_ctl_t      ctl;
  logic          g_en;
  logic          high_en;
  logic          seg_en;
  logic [1:0]    seg_code;
  logic          seg_active;
  logic [AW-1:0] tom;

  smm_cfg_regs #(.FIXED_LOW(FIXED_LOW)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .sel   (cfg_sel_e'(cfg_sel)),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl)
  );

  assign g_en     = ctl.g_en;
  assign high_en  = ctl.high_en;
  assign seg_en   = ctl.seg_en;
  assign seg_code = ctl.seg_code;

  smm_top_calc u_calc (
    .g_en       (g_en),
    .seg_en     (seg_en),
    .seg_code   (seg_code),
    .row_top    (ctl.row_top),
    .tom        (tom),
    .seg_active (seg_active),
    .usable_top (usable_top)
  );

  smm_window_match u_match (
    .host_addr  (host_addr),
    .g_en       (g_en),
    .high_en    (high_en),
    .seg_active (seg_active),
    .tom        (tom),
    .usable_top (usable_top),
    .hit_compat (hit_compat),
    .hit_high   (hit_high),
    .hit_tseg   (hit_tseg),
    .dram_addr  (dram_addr)
  );
endmodule

// File: rtl/smm_window_decoder_chk.sv
module smm_window_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_en,
  input logic [1:0]  cfg_sel,
  input logic [7:0]  cfg_wdata,
  input logic [7:0]  cfg_rdata,
  input logic [31:0] host_addr,
  input logic        hit_compat,
  input logic        hit_high,
  input logic        hit_tseg,
  input logic [31:0] dram_addr,
  input logic [31:0] usable_top,
  input logic [31:0] tom,
  input logic        g_en,
  input logic        high_en,
  input logic        seg_en,
  input logic [1:0]  seg_code,
  input logic        seg_active
);
  p_fixed_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sel == 2'd0) |-> (cfg_rdata[2:0] == 3'b010));

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_sel == 2'd1) |=>
      (high_en == $past(cfg_wdata[7]) && seg_en == $past(cfg_wdata[0]) &&
       seg_code == $past(cfg_wdata[2:1])));

  p_usable_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_active |-> (usable_top == tom));

  p_usable_below_r5: assert property (@(posedge clk) disable iff (!rst_n)
    usable_top <= tom);

  p_seg_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_tseg |-> (host_addr < tom && host_addr >= usable_top));

  p_high_remap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_high |-> (dram_addr == host_addr - 32'h1000_0000 &&
                  host_addr >= 32'h100A_0000 && host_addr <= 32'h100F_FFFF));

  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_high |-> (dram_addr == host_addr));

  p_gated_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !g_en |-> (!hit_compat && !hit_high && !hit_tseg));

  p_single_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_compat, hit_high, hit_tseg}));
endmodule

bind smm_window_decoder smm_window_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_wr_en  (cfg_wr_en),
  .cfg_sel    (cfg_sel),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .host_addr  (host_addr),
  .hit_compat (hit_compat),
  .hit_high   (hit_high),
  .hit_tseg   (hit_tseg),
  .dram_addr  (dram_addr),
  .usable_top (usable_top),
  .tom        (tom),
  .g_en       (g_en),
  .high_en    (high_en),
  .seg_en     (seg_en),
  .seg_code   (seg_code),
  .seg_active (seg_active)
);

// File: tb/tb_smm_window_decoder.sv
`timescale 1ns/1ps
module tb_smm_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic [7:0]  cfg_rdata;
  logic [31:0] host_addr = 32'h0;
  logic        hit_compat, hit_high, hit_tseg;
  logic [31:0] dram_addr, usable_top;

  always #2 clk = ~clk;

  smm_window_decoder dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .host_addr(host_addr),
    .hit_compat(hit_compat), .hit_high(hit_high), .hit_tseg(hit_tseg),
    .dram_addr(dram_addr), .usable_top(usable_top)
  );

  typedef struct {
    logic [7:0]  rd;
    logic        hc, hh, ht;
    logic [31:0] da, ut;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   sum_done = 0;

  logic [7:0] sh_glob = 8'h00, sh_ext = 8'h00, sh_row = 8'h00;

  function automatic exp_t model(input logic [31:0] a, input logic [1:0] s, input string tag);
    exp_t e;
    logic [31:0] top, sz;
    logic g, act;
    top = 32'(sh_row) * 32'h0080_0000;
    case (sh_ext[2:1])
      2'd0: sz = 32'h0002_0000;
      2'd1: sz = 32'h0004_0000;
      2'd2: sz = 32'h0008_0000;
      default: sz = 32'h0010_0000;
    endcase
    g   = sh_glob[3];
    act = g & sh_ext[0];
    if (!act) e.ut = top;
    else if (sz > top) e.ut = 32'h0;
    else e.ut = top - sz;
    case (s)
      2'd0: e.rd = {sh_glob[7:3], 3'b010};
      2'd1: e.rd = sh_ext;
      2'd2: e.rd = sh_row;
      default: e.rd = 8'h00;
    endcase
    e.hh = g && sh_ext[7] && a >= 32'h100A_0000 && a < 32'h1010_0000;
    e.hc = g && !sh_ext[7] && a >= 32'h000A_0000 && a < 32'h000C_0000;
    e.ht = act && a >= e.ut && a < top;
    e.da = e.hh ? {a[31:29], 1'b0, a[27:0]} : a;
    e.tag = tag;
    return e;
  endfunction

  task automatic probe(input logic [31:0] a, input logic [1:0] s, input string tag);
    @(posedge clk); #1;
    host_addr = a;
    cfg_sel   = s;
    q.push_back(model(a, s, tag));
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    case (s)
      2'd0: sh_glob = d;
      2'd1: sh_ext  = d;
      2'd2: sh_row  = d;
      default: ;
    endcase
  endtask

  // R10: compare old results in the strobe cycle, new results after the edge
  task automatic wr_timed(input logic [1:0] s, input logic [7:0] d, input logic [31:0] a);
    @(posedge clk); #1;
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d; host_addr = a;
    q.push_back(model(a, s, "R10 before edge"));
    @(posedge clk); #1;
    cfg_wr_en = 1'b0;
    case (s)
      2'd0: sh_glob = d;
      2'd1: sh_ext  = d;
      2'd2: sh_row  = d;
      default: ;
    endcase
    q.push_back(model(a, s, "R10 after edge"));
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        n_vec++;
        bad = 0;
        if (cfg_rdata !== e.rd) begin bad = 1;
          $display("FAIL %s: cfg_rdata got %h exp %h", e.tag, cfg_rdata, e.rd); end
        if ({hit_compat, hit_high, hit_tseg} !== {e.hc, e.hh, e.ht}) begin bad = 1;
          $display("FAIL %s: hits got %b exp %b", e.tag, {hit_compat, hit_high, hit_tseg},
                   {e.hc, e.hh, e.ht}); end
        if (dram_addr !== e.da) begin bad = 1;
          $display("FAIL %s: dram_addr got %h exp %h", e.tag, dram_addr, e.da); end
        if (usable_top !== e.ut) begin bad = 1;
          $display("FAIL %s: usable_top got %h exp %h", e.tag, usable_top, e.ut); end
        if (bad) n_bad++;
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!sum_done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    probe(32'h000A_0000, 2'd0, "R1 global");
    probe(32'h000A_0000, 2'd1, "R1 ext");
    probe(32'h0000_0000, 2'd2, "R1 rowtop");
    // R2 hardwired low bits
    wr(2'd0, 8'hF5);
    probe(32'h0000_1000, 2'd0, "R2 write F5");
    wr(2'd0, 8'h00);
    probe(32'h0000_1000, 2'd0, "R2 write 00");
    // R3 readback
    wr(2'd1, 8'h5A);
    probe(32'h0, 2'd1, "R3 ext");
    wr(2'd2, 8'h10);
    probe(32'h0, 2'd2, "R3 rowtop");
    probe(32'h0, 2'd3, "R3 unused select");
    // R9 / R4: master off, ext full on
    wr(2'd1, 8'h87);
    probe(32'h07FF_FFFF, 2'd1, "R9 seg off");
    probe(32'h100A_0000, 2'd1, "R9 high off");
    wr(2'd1, 8'h07);
    probe(32'h000A_0000, 2'd0, "R9 compat off R4 top");
    // R5 / R6 master on, 1 MiB
    wr(2'd0, 8'h08);
    probe(32'h07F0_0000, 2'd1, "R6 seg low edge");
    probe(32'h07EF_FFFF, 2'd1, "R6 below seg");
    probe(32'h07FF_FFFF, 2'd1, "R6 seg high edge");
    probe(32'h0800_0000, 2'd1, "R6 at top");
    for (int c = 0; c < 3; c++) begin
      wr(2'd1, 8'((c << 1) | 1));
      probe(32'h07FE_0000, 2'd1, "R5 size code");
    end
    // R8 compatible window
    wr(2'd1, 8'h00);
    probe(32'h000A_0000, 2'd0, "R8 compat lo");
    probe(32'h000B_FFFF, 2'd0, "R8 compat hi");
    probe(32'h0009_FFFF, 2'd0, "R8 below");
    probe(32'h000C_0000, 2'd0, "R8 above");
    probe(32'h100A_0000, 2'd0, "R8 high not enabled");
    // R7 high window
    wr(2'd1, 8'h80);
    probe(32'h100A_0000, 2'd1, "R7 high lo");
    probe(32'h100F_FFFF, 2'd1, "R7 high hi");
    probe(32'h1009_FFFF, 2'd1, "R7 below");
    probe(32'h1010_0000, 2'd1, "R7 above");
    probe(32'h000A_0000, 2'd1, "R7 compat closed");
    // R5 saturation with zero memory
    wr(2'd1, 8'h07);
    wr(2'd2, 8'h00);
    probe(32'h0000_0000, 2'd2, "R5 saturate");
    // R4 large memory, segment off
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    probe(32'h7F7F_FFFF, 2'd2, "R4 top max");
    // R10 timing
    wr_timed(2'd1, 8'h81, 32'h7F7E_0000);
    wr_timed(2'd0, 8'h00, 32'h100A_0000);
    repeat (4) @(posedge clk);
    sum_done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule